// File: doc/BRIEF.md
# Recursive QR-Update Array with Shift-Add Rotators

This block keeps an upper-triangular matrix R and a transformed reference column u for a four-channel receive array, and refreshes both each time a new snapshot arrives. A snapshot holds one real sample per antenna plus one reference sample. It is absorbed into the stored triangle by a cascade of plane rotations.

On each stored row, a diagonal position first measures the angle that zeroes the incoming element against the stored diagonal. That position works in vectoring mode and keeps a record of one direction bit per micro-step. The off-diagonal positions of the same row then reuse those direction bits in rotating mode. Each one turns its stored entry and the incoming element through the same angle. The rotated incoming elements, the residuals, move down to feed the next row.

All fourteen triangle positions share one iterative shift-add rotator, so a snapshot takes a few hundred cycles. Results are fetched through a row/column read index. Column 4 selects u.

Samples use 16-bit signed Q2.13 (1.0 = 0x2000). The input follows a valid/ready handshake with back-pressure. A snapshot is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The producer must hold `in_row` steady while `in_valid` is high and `in_ready` is low. A snapshot offered while `in_ready` is low is not taken and is not queued.

Top module: `qrd_rls_array`

## Requirements
- R1: After reset, every readable entry of R and u reads 0, `in_ready` is 1 and `done` is 0.
- R2: The snapshot on `in_row` is taken at a rising edge with `in_valid` and `in_ready` both 1. Element i sits in bits [16i+15:16i] for i = 0..3, and the reference sits in bits [79:64]. From the next cycle `in_ready` stays 0 until the update ends. Anything offered on `in_valid` meanwhile leaves R and u untouched.
- R3: `done` is high for exactly one cycle per snapshot, in the same cycle that `in_ready` returns to 1. From that cycle on, the read port shows the updated entries.
- R4: For each row k, with stored diagonal r and incoming element x, the diagonal becomes sqrt(r² + x²). The stored diagonal is never negative.
- R5: For c = r/sqrt(r² + x²) and s = x/sqrt(r² + x²), each off-diagonal entry a of row k with incoming element b becomes c·a + s·b. The residual −s·a + c·b becomes row k+1's incoming element in that column. Rows are processed from 0 to 3.
- R6: u[k] (column 4) is rotated exactly like an off-diagonal entry. Its incoming element in row 0 is the reference sample.
- R7: When a row's incoming diagonal element is exactly zero, every entry of that row keeps its exact code, and the residuals pass down unchanged.
- R8: Any result outside the Q2.13 range is clamped: to 0x7FFF when positive, to 0x8000 when negative.
- R9: `rd_data` returns the entry at (`rd_row`, `rd_col`) for `rd_col` ≥ `rd_row` and `rd_col` ≤ 4. It returns 0 for every other index pair.
- R10: With 12 micro-steps and a shift-add gain correction near 0.6073, each entry lies within 0.02 of exact real-valued Givens arithmetic applied with the same clamping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Snapshot offered |
| in_ready | output | 1 | Block can take a snapshot |
| in_row | input | 80 | Four antenna samples and one reference, Q2.13 each |
| done | output | 1 | One-cycle pulse when the update is finished |
| rd_row | input | 2 | Read row index |
| rd_col | input | 3 | Read column index, 4 selects u |
| rd_data | output | 16 | Selected entry, Q2.13 |

## Verification
The bench targets the first snapshot after reset. There the stored diagonal is zero, so the rotation is ±90°. A rotator that mishandles a zero or negative x-coordinate returns wrong signs for the whole first row.

Snapshots whose diagonal element is exactly zero are checked for bit-exact preservation of the row. A design without the bypass would spin the row through the full micro-step angle sum and corrupt it.

A second snapshot offered during an update must leave no mark; an input that absorbs it shifts every entry. Two large equal snapshots push a diagonal above 4 and an off-diagonal below −4, which exposes wrap-around in place of clamping. Lower-triangle and out-of-range reads must return zero.

// File: rtl/qrd_pkg.sv
package qrd_pkg;

  typedef enum logic {
    MODE_VEC = 1'b0,
    MODE_ROT = 1'b1
  } cordic_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/qrd_gain_comp.sv
// Constant scaling by about 0.60730 using shifts and adds only:
// 1/2 + 1/8 - 1/64 - 1/512 - 1/8192.
module qrd_gain_comp #(
  parameter int WI = 20
) (
  input  logic signed [WI-1:0] v,
  output logic signed [WI-1:0] p
);

  assign p = (v >>> 1) + (v >>> 3) - (v >>> 6) - (v >>> 9) - (v >>> 13);

endmodule

// File: rtl/qrd_cordic_engine.sv
// Iterative shift-add rotator: one micro-step per cycle.
// Vectoring mode drives y toward zero and records one direction bit per step.
// Rotating mode replays a supplied bit set.
module qrd_cordic_engine
  import qrd_pkg::*;
#(
  parameter int W    = 16,
  parameter int ITER = 12,
  parameter int G    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  cordic_mode_e        mode,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] y_in,
  input  logic [ITER-1:0]     dirs_in,
  output logic                busy,
  output logic                done,
  output logic signed [W-1:0] x_out,
  output logic signed [W-1:0] y_out,
  output logic [ITER-1:0]     dirs_out
);

  localparam int WI   = W + 2 * G;
  localparam int IW   = $clog2(ITER);
  localparam int YTOL = 1 << (W - 9);
  localparam logic signed [WI-1:0] HI = WI'((1 << (W - 1)) - 1);
  localparam logic signed [WI-1:0] LO = -HI - 1;

  function automatic logic signed [WI-1:0] widen(input logic signed [W-1:0] v);
    return {{G{v[W-1]}}, v, {G{1'b0}}};
  endfunction

  function automatic logic signed [W-1:0] clamp(input logic signed [WI-1:0] v);
    logic signed [WI-1:0] t;
    t = v >>> G;
    if (t > HI) return HI[W-1:0];
    if (t < LO) return LO[W-1:0];
    return t[W-1:0];
  endfunction

  logic signed [WI-1:0] x_q, y_q;
  logic [IW-1:0]        it_q;
  cordic_mode_e         mode_q;
  logic [ITER-1:0]      dirs_q;
  logic                 busy_q, done_q;
  logic signed [W-1:0]  xo_q, yo_q;

  logic signed [WI-1:0] xs, ys, xn, yn;
  logic                 neg;
  logic signed [WI-1:0] pre  [2];
  logic signed [WI-1:0] comp [2];

  always_comb begin
    xs  = x_q >>> it_q;
    ys  = y_q >>> it_q;
    neg = (mode_q == MODE_VEC) ? y_q[WI-1] : dirs_q[it_q];
    if (neg) begin
      xn = x_q - ys;
      yn = y_q + xs;
    end else begin
      xn = x_q + ys;
      yn = y_q - xs;
    end
    pre[0] = xn;
    pre[1] = yn;
  end

  genvar gc;
  generate
    for (gc = 0; gc < 2; gc++) begin : g_comp
      qrd_gain_comp #(.WI(WI)) u_comp (
        .v(pre[gc]),
        .p(comp[gc])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      it_q   <= '0;
      mode_q <= MODE_VEC;
      dirs_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      xo_q   <= '0;
      yo_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        x_q    <= widen(x_in);
        y_q    <= widen(y_in);
        it_q   <= '0;
        mode_q <= mode;
        dirs_q <= (mode == MODE_VEC) ? '0 : dirs_in;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        x_q  <= xn;
        y_q  <= yn;
        it_q <= it_q + 1'b1;
        if (mode_q == MODE_VEC) dirs_q[it_q] <= neg;
        if (it_q == IW'(ITER - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          xo_q   <= clamp(comp[0]);
          yo_q   <= clamp(comp[1]);
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign x_out    = xo_q;
  assign y_out    = yo_q;
  assign dirs_out = dirs_q;

  AST_VEC_NULLS_Y: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && mode_q == MODE_VEC) |-> ((yo_q < W'(YTOL)) && (yo_q > -W'(YTOL)))); // R4

  AST_VEC_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && mode_q == MODE_VEC) |-> !xo_q[W-1]); // R4

endmodule

// File: rtl/qrd_tri_store.sv
// Upper-triangular register file: N rows by N+1 columns, the last column is u.
// Port a is the external read, port b feeds the sequencer.
module qrd_tri_store #(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [$clog2(N)-1:0]          wr_row,
  input  logic [$clog2(N+1)-1:0]        wr_col,
  input  logic signed [W-1:0]           wr_data,
  input  logic [$clog2(N)-1:0]          ra_row,
  input  logic [$clog2(N+1)-1:0]        ra_col,
  output logic signed [W-1:0]           ra_data,
  input  logic [$clog2(N)-1:0]          rb_row,
  input  logic [$clog2(N+1)-1:0]        rb_col,
  output logic signed [W-1:0]           rb_data
);

  localparam int M  = N + 1;
  localparam int RW = $clog2(N);
  localparam int CW = $clog2(M);

  logic signed [W-1:0] cell_q [N][M];

  always_ff @(posedge clk) begin
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < M; c++) begin
        if (!rst_n || c < r) begin
          cell_q[r][c] <= '0;
        end else if (we && wr_row == RW'(r) && wr_col == CW'(c)) begin
          cell_q[r][c] <= wr_data;
        end
      end
    end
  end

  always_comb begin
    ra_data = '0;
    rb_data = '0;
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < M; c++) begin
        if (c >= r) begin
          if (ra_row == RW'(r) && ra_col == CW'(c)) ra_data = cell_q[r][c];
          if (rb_row == RW'(r) && rb_col == CW'(c)) rb_data = cell_q[r][c];
        end
      end
    end
  end

  AST_DIAG_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wr_col == CW'(wr_row)) |-> !wr_data[W-1]); // R4

  AST_WRITE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (wr_col >= CW'(wr_row) && wr_col <= CW'(M - 1))); // R9

endmodule

// File: rtl/qrd_rls_array.sv
// Folded triangular rotation array: one shared rotator visits every cell,
// row by row, diagonal first, then left to right across the row.
module qrd_rls_array
  import qrd_pkg::*;
#(
  parameter int N    = 4,
  parameter int W    = 16,
  parameter int ITER = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [(N+1)*W-1:0]       in_row,
  output logic                     done,
  input  logic [$clog2(N)-1:0]     rd_row,
  input  logic [$clog2(N+1)-1:0]   rd_col,
  output logic signed [W-1:0]      rd_data
);

  localparam int M  = N + 1;
  localparam int RW = $clog2(N);
  localparam int CW = $clog2(M);

  seq_state_e          state_q;
  logic [RW-1:0]       k_q;
  logic [CW-1:0]       j_q;
  logic                ident_q;
  logic [ITER-1:0]     dirs_q;
  logic                done_q;
  logic signed [W-1:0] xrow_q   [M];
  logic signed [W-1:0] row_elem [M];

  genvar gi;
  generate
    for (gi = 0; gi < M; gi++) begin : g_unpack
      assign row_elem[gi] = in_row[gi*W +: W];
    end
  endgenerate

  logic                is_diag, xin_zero, bypass, last_cell, row_end;
  logic signed [W-1:0] r_cur;
  logic                eng_start, eng_busy, eng_done;
  logic signed [W-1:0] eng_x, eng_y;
  logic [ITER-1:0]     eng_dirs;
  logic                st_we;

  always_comb begin
    is_diag   = (j_q == CW'(k_q));
    xin_zero  = (xrow_q[j_q] == '0);
    bypass    = is_diag ? xin_zero : ident_q;
    row_end   = (j_q == CW'(M - 1));
    last_cell = row_end && (k_q == RW'(N - 1));
    eng_start = (state_q == SEQ_ISSUE) && !bypass;
    st_we     = (state_q == SEQ_WAIT) && eng_done;
  end

  qrd_cordic_engine #(.W(W), .ITER(ITER), .G(2)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (eng_start),
    .mode     (is_diag ? MODE_VEC : MODE_ROT),
    .x_in     (r_cur),
    .y_in     (xrow_q[j_q]),
    .dirs_in  (dirs_q),
    .busy     (eng_busy),
    .done     (eng_done),
    .x_out    (eng_x),
    .y_out    (eng_y),
    .dirs_out (eng_dirs)
  );

  qrd_tri_store #(.N(N), .W(W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (st_we),
    .wr_row  (k_q),
    .wr_col  (j_q),
    .wr_data (eng_x),
    .ra_row  (rd_row),
    .ra_col  (rd_col),
    .ra_data (rd_data),
    .rb_row  (k_q),
    .rb_col  (j_q),
    .rb_data (r_cur)
  );

  logic advance;
  assign advance = (state_q == SEQ_ISSUE && bypass) || (state_q == SEQ_WAIT && eng_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      k_q     <= '0;
      j_q     <= '0;
      ident_q <= 1'b0;
      dirs_q  <= '0;
      done_q  <= 1'b0;
      for (int i = 0; i < M; i++) xrow_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (in_valid) begin
            for (int i = 0; i < M; i++) xrow_q[i] <= row_elem[i];
            k_q     <= '0;
            j_q     <= '0;
            state_q <= SEQ_ISSUE;
          end
        end
        SEQ_ISSUE: begin
          if (is_diag) ident_q <= xin_zero;
          if (!bypass) state_q <= SEQ_WAIT;
        end
        SEQ_WAIT: begin
          if (eng_done) begin
            if (is_diag) dirs_q <= eng_dirs;
            else         xrow_q[j_q] <= eng_y;
            state_q <= SEQ_ISSUE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
      if (advance) begin
        if (last_cell) begin
          state_q <= SEQ_IDLE;
          done_q  <= 1'b1;
        end else if (row_end) begin
          k_q <= k_q + 1'b1;
          j_q <= CW'(k_q) + CW'(1);
        end else begin
          j_q <= j_q + 1'b1;
        end
      end
    end
  end

  assign in_ready = (state_q == SEQ_IDLE);
  assign done     = done_q;

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (in_ready && !$past(in_ready))); // R3

  AST_ENGINE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !eng_busy); // R5

endmodule

// File: tb/qrd_rls_array_tb.sv
module qrd_rls_array_tb;
  localparam int N = 4;
  localparam int W = 16;
  localparam int M = N + 1;
  localparam real TOL = 0.02;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [M*W-1:0] in_row = '0;
  logic           done;
  logic [1:0]     rd_row = '0;
  logic [2:0]     rd_col = '0;
  logic [W-1:0]   rd_data;

  qrd_rls_array u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_row(in_row), .done(done), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );

  int  checks = 0;
  int  errors = 0;
  int  cyc    = 0;
  real rm [N][M];
  real xv [M];

  // {ref, x3, x2, x1, x0}
  localparam logic [M*W-1:0] STIM [6] = '{
    80'h1800_0800_F000_1000_2000,
    80'hF800_E000_0800_2000_F000,
    80'h2000_1000_2000_F800_0800,
    80'h1000_2000_F000_0800_1000,
    80'hF000_0800_1800_F000_E000,
    80'h0800_F000_F800_2000_1800
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog R3: actual no finish, expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic real to_r(input logic [W-1:0] v);
    return $itor($signed(v)) / 8192.0;
  endfunction

  function automatic real clampr(input real v);
    if (v > 4.0 - 1.0/8192.0) return 4.0 - 1.0/8192.0;
    if (v < -4.0) return -4.0;
    return v;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < N; k++) for (int j = 0; j < M; j++) rm[k][j] = 0.0;
  endtask

  task automatic model_row(input logic [M*W-1:0] row);
    real r, x, rp, c, s, a, b;
    for (int i = 0; i < M; i++) xv[i] = to_r(row[i*W +: W]);
    for (int k = 0; k < N; k++) begin
      r = rm[k][k];
      x = xv[k];
      if (x != 0.0) begin
        rp = $sqrt(r*r + x*x);
        c = r / rp;
        s = x / rp;
        rm[k][k] = clampr(rp);
        for (int j = k + 1; j < M; j++) begin
          a = rm[k][j];
          b = xv[j];
          rm[k][j] = clampr(c*a + s*b);
          xv[j]    = clampr(-s*a + c*b);
        end
      end
    end
  endtask

  task automatic rd(input int r, input int c, output logic [W-1:0] v);
    rd_row = r[1:0];
    rd_col = c[2:0];
    #1;
    v = rd_data;
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_code(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_real(input string tag, input int r, input int c, input logic [W-1:0] act, input real exp);
    real a;
    a = to_r(act);
    checks++;
    if ((a - exp) > TOL || (exp - a) > TOL) begin
      errors++;
      $display("FAIL %s at (%0d,%0d): actual %f expected %f", tag, r, c, a, exp);
    end
  endtask

  task automatic cmp_all();
    logic [W-1:0] v;
    for (int k = 0; k < N; k++) begin
      for (int j = k; j < M; j++) begin
        rd(k, j, v);
        if (j == k)          chk_real("R4 R10 diagonal", k, j, v, rm[k][j]);
        else if (j == M - 1) chk_real("R6 R10 u entry", k, j, v, rm[k][j]);
        else                 chk_real("R5 R10 off-diagonal", k, j, v, rm[k][j]);
      end
    end
  endtask

  // Offer one snapshot; optionally offer a second one while busy (must be ignored).
  task automatic send_row(input logic [M*W-1:0] row, input bit extra, input logic [M*W-1:0] other);
    int n;
    logic [W-1:0] v;
    model_row(row);
    @(negedge clk);
    in_row   = row;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit("R2 in_ready low after accept", in_ready, 1'b0);
    if (extra) begin
      in_row   = other;
      in_valid = 1'b1;
      repeat (4) @(negedge clk);
      chk_bit("R2 in_ready low while second row offered", in_ready, 1'b0);
      in_valid = 1'b0;
    end
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk_bit("R3 done pulse seen", done, 1'b1);
    chk_bit("R3 in_ready high with done", in_ready, 1'b1);
    rd(0, 0, v);
    chk_real("R3 result readable at done", 0, 0, v, rm[0][0]);
    @(negedge clk);
    chk_bit("R3 done lasts one cycle", done, 1'b0);
  endtask

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] saved [M];

    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk_bit("R1 in_ready after reset", in_ready, 1'b1);
    chk_bit("R1 done after reset", done, 1'b0);
    for (int k = 0; k < N; k++)
      for (int j = k; j < M; j++) begin
        rd(k, j, v);
        chk_code("R1 entry zero after reset", v, '0);
      end

    // Vector table walk
    for (int t = 0; t < 6; t++) begin
      send_row(STIM[t], 1'b0, '0);
      cmp_all();
    end

    // R2: a row offered while busy leaves no trace
    send_row(80'h1000_F000_2000_E000_0800, 1'b1, 80'h3000_3000_3000_3000_3000);
    cmp_all();

    // R7: zero diagonal input leaves row 0 bit-exact
    for (int j = 0; j < M; j++) rd(0, j, saved[j]);
    send_row(80'h1000_F000_0800_2000_0000, 1'b0, '0);
    for (int j = 0; j < M; j++) begin
      rd(0, j, v);
      chk_code("R7 row 0 unchanged", v, saved[j]);
    end
    cmp_all();

    // R9: lower triangle and out-of-range columns read zero
    for (int k = 0; k < N; k++)
      for (int j = 0; j < 8; j++)
        if (j < k || j > N) begin
          rd(k, j, v);
          chk_code("R9 unused index reads zero", v, '0);
        end

    // R8: saturation after reset
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model_clear();
    chk_bit("R1 in_ready after second reset", in_ready, 1'b1);
    rd(0, 0, v);
    chk_code("R1 diagonal cleared by reset", v, '0);
    send_row(80'h0000_0000_0000_8333_7CCD, 1'b0, '0);
    cmp_all();
    send_row(80'h0000_0000_0000_8333_7CCD, 1'b0, '0);
    rd(0, 0, v);
    chk_code("R8 diagonal clamps high", v, 16'h7FFF);
    rd(0, 1, v);
    chk_code("R8 off-diagonal clamps low", v, 16'h8000);
    cmp_all();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule